// File: doc/BRIEF.md
# PLL Lock Qualifier

A phase-locked loop's raw lock indication is a pulsing signal. It can fall for a whole comparison period whenever the loop slips. This block turns that signal into one steady status bit, which higher-level logic places at the end of a response word. The raw input is sampled once every two bus clocks. The block counts how many samples are HIGH within a fixed window. At the close of each window it compares that count with a programmable threshold.

Two settings come from a command port. Each command is three data bytes presented with a one-cycle strobe. A setup command picks the window length, which is either 80 or 84 samples. A normal command loads a 7-bit threshold. A command whose bytes match neither pattern changes nothing. The status bit changes only at window boundaries, so software reads a value that was decided over one complete window.

Top module: `lock_qualifier`

## Requirements
- R1: While `rst` is high and after it falls, `lock_o` is 0, the window length is 80 samples and the threshold is 127.
- R2: The raw input is sampled on every second clock edge. The first sample is taken on the second rising edge after `rst` falls, and no sample is taken on two consecutive edges.
- R3: A strobed command with byte 2 bits [7:6] = 10, byte 3 bit 5 = 1 and byte 3 bits [1:0] = 00 is a setup command. Its byte 1 bit 5 selects the window length: 0 gives 80 samples and 1 gives 84 samples.
- R4: A new window length takes effect at the next window boundary. The window already in progress finishes with its old length.
- R5: A strobed command with byte 2 bits [7:6] = 01 and byte 2 bit 4 = 1 loads the threshold from byte 1 bits [7:1].
- R6: On the clock edge of a window's last sample, `lock_o` becomes 1 if the number of HIGH samples in that window, the last sample included, is greater than or equal to the threshold. Otherwise it becomes 0.
- R7: `lock_o` does not change on any edge other than the last sample of a window.
- R8: The HIGH-sample count starts from zero in each new window.
- R9: A strobed command that matches neither pattern leaves the window length and the threshold unchanged.
- R10: The HIGH-sample count never exceeds the active window length, and the position within the window stays below that length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_raw_i | input | 1 | Raw, pulsing lock indication from the loop |
| cmd_vld_i | input | 1 | One-cycle strobe that qualifies the three command bytes |
| cmd_b1_i | input | 8 | Command data byte 1: carries the window select and the threshold value |
| cmd_b2_i | input | 8 | Command data byte 2: carries the command type bits |
| cmd_b3_i | input | 8 | Command data byte 3: carries the extra setup qualifier bits |
| lock_o | output | 1 | Registered lock status |

## Verification
The assertions take for granted that the command bytes are valid whenever the strobe is high. They also assume that reset is held long enough to clear the sampling phase, so the first sample after reset is aligned. The bench drives each command for exactly one clock, inside the first clock of a two-clock sample slot. It changes the raw input only on falling edges at the start of a slot, so every sample sees a stable value. Every scenario starts from a fresh reset, which keeps the bench's own count of samples aligned with the window boundaries.

// File: rtl/lq_pkg.sv
package lq_pkg;
  localparam int WIN_SHORT = 80;
  localparam int WIN_LONG  = 84;
  localparam int THR_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = $clog2(WIN_LONG + 1);
  localparam logic [THR_W-1:0] THR_RESET = '1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [THR_W-1:0] thr_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SETUP = 2'd1,
    CMD_THR   = 2'd2
  } cmd_kind_e;

  function automatic cnt_t win_len(input logic sel);
    win_len = sel ? cnt_t'(WIN_LONG) : cnt_t'(WIN_SHORT);
  endfunction

  function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b2,
                                         input logic [BYTE_W-1:0] b3);
    if (b2[7:6] == 2'b10 && b3[5] && b3[1:0] == 2'b00)
      classify = CMD_SETUP;
    else if (b2[7:6] == 2'b01 && b2[4])
      classify = CMD_THR;
    else
      classify = CMD_NONE;
  endfunction

  function automatic thr_t thr_field(input logic [BYTE_W-1:0] b1);
    thr_field = b1[7:1];
  endfunction

  function automatic logic verdict(input cnt_t hits, input thr_t thr);
    verdict = ({1'b0, hits} >= {{(CNT_W + 1 - THR_W){1'b0}}, thr});
  endfunction
endpackage

// File: rtl/lq_sample_tick.sv
module lq_sample_tick (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign tick_o = phase_q;
endmodule

// File: rtl/lq_cmd_decode.sv
module lq_cmd_decode
  import lq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] b1_i,
  input  logic [BYTE_W-1:0] b2_i,
  input  logic [BYTE_W-1:0] b3_i,
  output logic              setup_hit_o,
  output logic              thr_hit_o,
  output logic              sel_o,
  output thr_t              thr_o
);
  cmd_kind_e kind;
  logic      sel_q;
  thr_t      thr_q;

  always_comb begin
    kind = vld_i ? classify(b2_i, b3_i) : CMD_NONE;
  end

  assign setup_hit_o = (kind == CMD_SETUP);
  assign thr_hit_o   = (kind == CMD_THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      thr_q <= THR_RESET;
    end else begin
      if (setup_hit_o) sel_q <= b1_i[5];
      if (thr_hit_o)   thr_q <= thr_field(b1_i);
    end
  end

  assign sel_o = sel_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/lq_window_ctr.sv
module lq_window_ctr
  import lq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic sel_i,
  output logic win_end_o,
  output cnt_t pos_o,
  output cnt_t len_o
);
  cnt_t pos_q;
  cnt_t len_q;

  assign win_end_o = tick_i && (pos_q == len_q - cnt_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      len_q <= win_len(1'b0);
    end else if (win_end_o) begin
      pos_q <= '0;
      len_q <= win_len(sel_i);
    end else if (tick_i) begin
      pos_q <= pos_q + cnt_t'(1);
    end
  end

  assign pos_o = pos_q;
  assign len_o = len_q;
endmodule

// File: rtl/lq_hit_eval.sv
module lq_hit_eval
  import lq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic win_end_i,
  input  logic raw_i,
  input  thr_t thr_i,
  output cnt_t hits_o,
  output logic lock_o
);
  cnt_t hits_q;
  cnt_t hits_next;
  logic lock_q;

  assign hits_next = hits_q + cnt_t'(raw_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q <= '0;
      lock_q <= 1'b0;
    end else if (win_end_i) begin
      lock_q <= verdict(hits_next, thr_i);
      hits_q <= '0;
    end else if (tick_i) begin
      hits_q <= hits_next;
    end
  end

  assign hits_o = hits_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import lq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_raw_i,
  input  logic              cmd_vld_i,
  input  logic [BYTE_W-1:0] cmd_b1_i,
  input  logic [BYTE_W-1:0] cmd_b2_i,
  input  logic [BYTE_W-1:0] cmd_b3_i,
  output logic              lock_o
);
  logic tick;
  logic win_end;
  logic setup_hit;
  logic thr_hit;
  logic sel;
  thr_t thr;
  cnt_t pos;
  cnt_t len;
  cnt_t hits;

  lq_sample_tick u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  lq_cmd_decode u_cmd (
    .clk         (clk),
    .rst         (rst),
    .vld_i       (cmd_vld_i),
    .b1_i        (cmd_b1_i),
    .b2_i        (cmd_b2_i),
    .b3_i        (cmd_b3_i),
    .setup_hit_o (setup_hit),
    .thr_hit_o   (thr_hit),
    .sel_o       (sel),
    .thr_o       (thr)
  );

  lq_window_ctr u_win (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .sel_i     (sel),
    .win_end_o (win_end),
    .pos_o     (pos),
    .len_o     (len)
  );

  lq_hit_eval u_eval (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .win_end_i (win_end),
    .raw_i     (lock_raw_i),
    .thr_i     (thr),
    .hits_o    (hits),
    .lock_o    (lock_o)
  );
endmodule

// File: rtl/lq_checker.sv
module lq_checker
  import lq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              win_end,
  input logic              setup_hit,
  input logic              thr_hit,
  input logic              cmd_vld_i,
  input logic [BYTE_W-1:0] cmd_b1_i,
  input logic              sel,
  input thr_t              thr,
  input cnt_t              pos,
  input cnt_t              len,
  input cnt_t              hits,
  input logic              lock_o
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!lock_o && thr == THR_RESET && len == cnt_t'(WIN_SHORT)));

  // R2: no sample on two consecutive edges
  a_r2_tick_alternates: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3: setup command loads the window select
  a_r3_sel_load: assert property (@(posedge clk) disable iff (rst)
    setup_hit |=> (sel == $past(cmd_b1_i[5])));

  // R5: threshold command loads the threshold
  a_r5_thr_load: assert property (@(posedge clk) disable iff (rst)
    thr_hit |=> (thr == $past(cmd_b1_i[7:1])));

  // R7: status only moves on a window's last sample
  a_r7_status_hold: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(lock_o));

  // R8: count is zero at the start of each window
  a_r8_count_clears: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (hits == '0 && pos == '0));

  // R9: unmatched command leaves settings alone
  a_r9_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld_i && !setup_hit && !thr_hit) |=> ($stable(thr) && $stable(sel)));

  // R10: counters stay inside the window
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (hits <= len) && (pos < len));
endmodule

bind lock_qualifier lq_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .win_end   (win_end),
  .setup_hit (setup_hit),
  .thr_hit   (thr_hit),
  .cmd_vld_i (cmd_vld_i),
  .cmd_b1_i  (cmd_b1_i),
  .sel       (sel),
  .thr       (thr),
  .pos       (pos),
  .len       (len),
  .hits      (hits),
  .lock_o    (lock_o)
);

// File: tb/lock_qualifier_tb.sv
module lock_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw = 1'b0;
  logic       cv = 1'b0;
  logic [7:0] b1 = '0, b2 = '0, b3 = '0;
  logic       lock;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  lock_qualifier u_dut (
    .clk        (clk),
    .rst        (rst),
    .lock_raw_i (raw),
    .cmd_vld_i  (cv),
    .cmd_b1_i   (b1),
    .cmd_b2_i   (b2),
    .cmd_b3_i   (b3),
    .lock_o     (lock)
  );

  // vector fields: {sel[15], thr[14:8], high samples[7:1], expected[0]}
  localparam logic [15:0] VEC [0:8] = '{
    {1'b0, 7'd42,  7'd80, 1'b1},
    {1'b0, 7'd42,  7'd42, 1'b1},
    {1'b0, 7'd42,  7'd41, 1'b0},
    {1'b1, 7'd70,  7'd84, 1'b1},
    {1'b1, 7'd84,  7'd84, 1'b1},
    {1'b0, 7'd84,  7'd80, 1'b0},
    {1'b1, 7'd127, 7'd84, 1'b0},
    {1'b0, 7'd0,   7'd0,  1'b1},
    {1'b1, 7'd72,  7'd71, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lock_o=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one two-clock sample slot; optional command in its first clock
  task automatic slot(input logic v, input logic c,
                      input logic [7:0] x1, input logic [7:0] x2, input logic [7:0] x3);
    raw = v; cv = c; b1 = x1; b2 = x2; b3 = x3;
    @(posedge clk);
    @(negedge clk);
    cv = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic v);
    for (int i = 0; i < n; i++) slot(v, 1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  function automatic logic [7:0] setup_b1(input logic s);
    setup_b1 = {2'b00, s, 5'b00000};
  endfunction

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 reset", lock, 1'b0);
    run(80, 1'b1);
    check("R1 threshold 127 not reached by 80", lock, 1'b0);

    // vector table: R3 R4 R5 R6
    for (int k = 0; k < 9; k++) begin
      logic       s;
      logic [6:0] t;
      int         n;
      int         len;
      s   = VEC[k][15];
      t   = VEC[k][14:8];
      n   = int'(VEC[k][7:1]);
      len = s ? 84 : 80;
      do_reset();
      slot(1'b0, 1'b1, setup_b1(s), 8'b1000_0000, 8'b0010_0000);
      slot(1'b0, 1'b1, {t, 1'b0}, 8'b0101_0000, 8'h00);
      run(78, 1'b0);
      for (int i = 0; i < len; i++) slot(i < n, 1'b0, 8'h00, 8'h00, 8'h00);
      check($sformatf("R6 vector %0d (sel=%0b thr=%0d high=%0d)", k, s, t, n),
            lock, VEC[k][0]);
    end

    // R4/R6 timing: 84-sample window chosen mid-window; first window stays 80
    do_reset();
    slot(1'b1, 1'b1, 8'h00, 8'b0101_0000, 8'h00); // thr 0
    slot(1'b1, 1'b1, setup_b1(1'b1), 8'b1000_0000, 8'b0010_0000);
    run(77, 1'b1);
    check("R6 not before last sample", lock, 1'b0);
    run(1, 1'b1);
    check("R4 first window still 80", lock, 1'b1);

    // R7 hold + R8 clear: lock with thr 42, then 41 highs
    do_reset();
    slot(1'b1, 1'b1, {7'd42, 1'b0}, 8'b0101_0000, 8'h00);
    run(79, 1'b1);
    check("R6 locked at 80 of 80", lock, 1'b1);
    run(41, 1'b1);
    run(38, 1'b0);
    check("R7 status held mid-window", lock, 1'b1);
    run(1, 1'b0);
    check("R8 count cleared, 41 < 42", lock, 1'b0);

    // R9: bad setup (byte3 bit5 clear) ignored, window stays 80
    do_reset();
    slot(1'b1, 1'b1, {7'd80, 1'b0}, 8'b0101_0000, 8'h00);
    slot(1'b1, 1'b1, setup_b1(1'b1), 8'b1000_0000, 8'b0000_0000);
    run(78, 1'b1);
    run(80, 1'b1);
    check("R9 bad setup ignored, window 80", lock, 1'b1);

    // R9: bad threshold (byte2 bit4 clear) ignored, threshold stays 127
    do_reset();
    slot(1'b0, 1'b1, 8'h00, 8'b0100_0000, 8'h00);
    run(79, 1'b0);
    check("R9 bad threshold ignored", lock, 1'b0);

    // R1: reset in mid-run drops status
    do_reset();
    slot(1'b1, 1'b1, 8'h00, 8'b0101_0000, 8'h00);
    run(79, 1'b1);
    check("R6 thr 0 locked", lock, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset clears status", lock, 1'b0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule